// File: doc/BRIEF.md
# External Interrupt Request Latch

This block collects two external interrupt sources for a processor core: an operator pushbutton and a signed interval timer that counts down. Each source has its own pending latch. A pending condition stays set until the interruption that reports it is taken, or until a program reset clears it. Each source has a subclass mask bit, taken from control register 0. The block raises one request line when at least one pending condition is unmasked and the status-word external mask is also set.

When the core takes the interruption, it reads a 16-bit interruption code. The code bits are numbered 0 to 15 from the most significant end. The timer sets bit 8 and the pushbutton sets bit 9. If both conditions are pending at the same time, they are merged into one code word. The take strobe clears exactly the conditions that the code is showing.

Top module: `ext_irq_latch`

## Requirements
- R1: A `key_press_i` pulse outside the load state sets the key pending condition on the next clock edge. The condition then holds until it is cleared by a take or a program reset.
- R2: With `KEY_LOAD_DROP`=1 (the default), a key press while `load_state_i` is high is discarded. With 0, it is latched like any other key press.
- R3: The timer is a `TMR_W`-bit signed register, reset to 0 and visible on `tmr_val_o`. A `tmr_load_i` cycle writes `tmr_load_val_i`. A `tmr_tick_i` cycle subtracts `TMR_STEP`. A load in the same cycle as a tick wins over the tick.
- R4: The timer pending condition is set only when a tick takes the value from zero or positive to negative. A load never sets it. A tick from an already negative value never sets it, and neither does a wrap from the most negative value to a positive value.
- R5: `irq_code_o` bit 7 shows the timer condition (code bit 8, MSB-first numbering). Bit 6 shows the key condition (code bit 9). Every other bit is zero. A condition appears in the code when it is pending and its subclass mask is one, whatever the value of `ext_mask_i`.
- R6: The subclass masks are loaded from `cr0_i` when `cr0_wr_i` is high: the key mask from bit index `KEY_MASK_BIT` (default 25) and the timer mask from `TMR_MASK_BIT` (default 24). Masking a condition hides it but does not clear it.
- R7: `irq_req_o` is high exactly when `ext_mask_i` is high and `irq_code_o` is nonzero.
- R8: An `irq_take_i` cycle clears only the conditions shown in the code. A pending condition that is masked stays pending. An event that arrives in the take cycle stays pending.
- R9: `prog_reset_i` clears both pending conditions on the next edge. It overrides any event in the same cycle and leaves the timer value unchanged.
- R10: Asserting `rst_ni` low immediately clears both pending conditions and the timer, and sets both subclass masks to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_press_i | input | 1 | Pushbutton activation pulse |
| load_state_i | input | 1 | CPU is in the load state |
| tmr_load_i | input | 1 | Write the timer |
| tmr_load_val_i | input | TMR_W | Value written to the timer |
| tmr_tick_i | input | 1 | Decrement the timer by TMR_STEP |
| cr0_wr_i | input | 1 | Load the subclass masks from cr0_i |
| cr0_i | input | CR_W | Control register 0 image |
| ext_mask_i | input | 1 | External mask from the current status word |
| irq_take_i | input | 1 | Interruption taken strobe |
| prog_reset_i | input | 1 | Program reset |
| irq_req_o | output | 1 | Enabled external interruption request |
| irq_code_o | output | 16 | Interruption code |
| tmr_val_o | output | TMR_W | Current timer value |

## Verification
The assertions check the following on every cycle:
- the fixed-zero bits of the code;
- the gating of the request by the external mask;
- key latching and holding;
- the load-state drop;
- the timer sign-crossing set;
- timer load;
- the clear done by program reset.

Some behaviour only the bench scenarios can show. These are the merged code for both conditions, and a take that clears a reported condition while a masked one survives. They also cover an event that collides with a take, a wrap from the most negative timer value, and a load in the same cycle as a tick. The mask reset values after an asynchronous reset are checked there as well.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned CODE_W  = 16;
  localparam int unsigned SRC_TMR = 0;
  localparam int unsigned SRC_KEY = 1;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [CODE_W-1:0]  irq_code_t;

  // code bit number, MSB-first
  function automatic int unsigned code_pos(int unsigned src);
    return (src == SRC_KEY) ? 9 : 8;
  endfunction

  function automatic int unsigned code_idx(int unsigned pos);
    return CODE_W - 1 - pos;
  endfunction
endpackage

// File: rtl/ext_irq_pend.sv
`timescale 1ns/1ps
module ext_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic prst_i,
  output logic q_o
);
  logic q_q;

  // program reset beats set; set beats take-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (prst_i) q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ext_irq_timer.sv
`timescale 1ns/1ps
module ext_irq_timer #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] val_o,
  output logic         fire_o
);
  localparam int unsigned SIGN = W - 1;

  logic [W-1:0] val_q;
  logic [W-1:0] dec;

  assign dec = val_q - W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (tick_i) val_q <= dec;
  end

  // sign goes 0 -> 1 on a real decrement only
  assign fire_o = tick_i & ~load_i & ~val_q[SIGN] & dec[SIGN];
  assign val_o  = val_q;
endmodule

// File: rtl/ext_irq_mask.sv
`timescale 1ns/1ps
module ext_irq_mask #(
  parameter int unsigned CR_W     = 32,
  parameter int unsigned KEY_BIT  = 25,
  parameter int unsigned TMR_BIT  = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CR_W-1:0]         cr_i,
  output ext_irq_pkg::src_vec_t   mask_o
);
  import ext_irq_pkg::*;

  src_vec_t mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr_i) begin
      mask_q[SRC_KEY] <= cr_i[KEY_BIT];
      mask_q[SRC_TMR] <= cr_i[TMR_BIT];
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ext_irq_latch.sv
`timescale 1ns/1ps
module ext_irq_latch #(
  parameter int unsigned TMR_W         = 32,
  parameter int unsigned TMR_STEP      = 1,
  parameter int unsigned CR_W          = 32,
  parameter int unsigned KEY_MASK_BIT  = 25,
  parameter int unsigned TMR_MASK_BIT  = 24,
  parameter bit          KEY_LOAD_DROP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_press_i,
  input  logic             load_state_i,
  input  logic             tmr_load_i,
  input  logic [TMR_W-1:0] tmr_load_val_i,
  input  logic             tmr_tick_i,
  input  logic             cr0_wr_i,
  input  logic [CR_W-1:0]  cr0_i,
  input  logic             ext_mask_i,
  input  logic             irq_take_i,
  input  logic             prog_reset_i,
  output logic             irq_req_o,
  output logic [15:0]      irq_code_o,
  output logic [TMR_W-1:0] tmr_val_o
);
  import ext_irq_pkg::*;

  src_vec_t  set_vec;
  src_vec_t  clr_vec;
  src_vec_t  pend_q;
  src_vec_t  mask;
  src_vec_t  shown;
  irq_code_t code;
  logic      key_set;
  logic      tmr_fire;

  generate
    if (KEY_LOAD_DROP) begin : g_drop
      assign key_set = key_press_i & ~load_state_i;
    end else begin : g_keep
      assign key_set = key_press_i;
    end
  endgenerate

  ext_irq_timer #(.W(TMR_W), .STEP(TMR_STEP)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load_i),
    .load_val_i (tmr_load_val_i),
    .tick_i     (tmr_tick_i),
    .val_o      (tmr_val_o),
    .fire_o     (tmr_fire)
  );

  ext_irq_mask #(.CR_W(CR_W), .KEY_BIT(KEY_MASK_BIT), .TMR_BIT(TMR_MASK_BIT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cr0_wr_i),
    .cr_i   (cr0_i),
    .mask_o (mask)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_KEY] = key_set;
    set_vec[SRC_TMR] = tmr_fire;
  end

  assign shown   = pend_q & mask;
  assign clr_vec = shown & {NUM_SRC{irq_take_i}};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ext_irq_pend u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[s]),
      .clr_i  (clr_vec[s]),
      .prst_i (prog_reset_i),
      .q_o    (pend_q[s])
    );
  end

  always_comb begin
    code = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      code[code_idx(code_pos(s))] = shown[s];
    end
  end

  assign irq_code_o = code;
  assign irq_req_o  = ext_mask_i & (|shown);
endmodule

// File: rtl/ext_irq_latch_chk.sv
`timescale 1ns/1ps
module ext_irq_latch_chk #(
  parameter int unsigned TMR_W         = 32,
  parameter int unsigned TMR_STEP      = 1,
  parameter bit          KEY_LOAD_DROP = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_press_i,
  input logic             load_state_i,
  input logic             tmr_load_i,
  input logic [TMR_W-1:0] tmr_load_val_i,
  input logic             tmr_tick_i,
  input logic             ext_mask_i,
  input logic             irq_take_i,
  input logic             prog_reset_i,
  input logic             irq_req_o,
  input logic [15:0]      irq_code_o,
  input logic [TMR_W-1:0] tmr_val_o,
  input logic             key_pend,
  input logic             tmr_pend
);
  p_code_zero_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_code_o[15:8] == 8'h00 && irq_code_o[5:0] == 6'h00);

  p_req_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mask_i |-> !irq_req_o);

  p_req_has_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_code_o != 16'h0);

  p_key_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_press_i && !load_state_i && !prog_reset_i |=> key_pend);

  p_key_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_pend && !prog_reset_i && !irq_take_i |=> key_pend);

  p_load_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    KEY_LOAD_DROP && key_press_i && load_state_i && !key_pend |=> !key_pend);

  p_tmr_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_load_i |=> tmr_val_o == $past(tmr_load_val_i));

  p_tmr_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_i && !tmr_load_i && !prog_reset_i && !tmr_val_o[TMR_W-1]
    && tmr_val_o < TMR_W'(TMR_STEP) |=> tmr_pend);

  p_prog_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_reset_i |=> !key_pend && !tmr_pend);
endmodule

bind ext_irq_latch ext_irq_latch_chk #(
  .TMR_W(TMR_W), .TMR_STEP(TMR_STEP), .KEY_LOAD_DROP(KEY_LOAD_DROP)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .key_press_i    (key_press_i),
  .load_state_i   (load_state_i),
  .tmr_load_i     (tmr_load_i),
  .tmr_load_val_i (tmr_load_val_i),
  .tmr_tick_i     (tmr_tick_i),
  .ext_mask_i     (ext_mask_i),
  .irq_take_i     (irq_take_i),
  .prog_reset_i   (prog_reset_i),
  .irq_req_o      (irq_req_o),
  .irq_code_o     (irq_code_o),
  .tmr_val_o      (tmr_val_o),
  .key_pend       (pend_q[ext_irq_pkg::SRC_KEY]),
  .tmr_pend       (pend_q[ext_irq_pkg::SRC_TMR])
);

// File: tb/tb_ext_irq_latch.sv
`timescale 1ns/1ps
module tb_ext_irq_latch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_press_i = 1'b0;
  logic        load_state_i = 1'b0;
  logic        tmr_load_i = 1'b0;
  logic [31:0] tmr_load_val_i = '0;
  logic        tmr_tick_i = 1'b0;
  logic        cr0_wr_i = 1'b0;
  logic [31:0] cr0_i = '0;
  logic        ext_mask_i = 1'b1;
  logic        irq_take_i = 1'b0;
  logic        prog_reset_i = 1'b0;
  logic        irq_req_o;
  logic [15:0] irq_code_o;
  logic [31:0] tmr_val_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [15:0] C_TMR = 16'h0080;
  localparam logic [15:0] C_KEY = 16'h0040;

  // {key, load_state, take, ext_mask, prog_reset, exp_req, exp_tmr, exp_key}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    8'b1001_0101,  // R1 press -> key pending, requested
    8'b0001_0101,  // R1 held
    8'b0000_0001,  // R7 ext mask off: code shown, no request
    8'b0011_0000,  // R8 take clears
    8'b1101_0000,  // R2 press in load state dropped
    8'b1001_0101,  // R1 press again
    8'b0001_1000,  // R9 program reset clears
    8'b1011_0101,  // R8 take with nothing shown, press latched
    8'b1011_0101,  // R8 press during take stays pending
    8'b0011_0000   // R8 take clears
  };

  ext_irq_latch dut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    key_press_i  = 1'b0;
    tmr_load_i   = 1'b0;
    tmr_tick_i   = 1'b0;
    cr0_wr_i     = 1'b0;
    irq_take_i   = 1'b0;
    prog_reset_i = 1'b0;
    load_state_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 reset req", 32'(irq_req_o), 32'd0);
    check("R10 reset code", 32'(irq_code_o), 32'd0);
    check("R10 reset timer", tmr_val_o, 32'd0);

    for (int i = 0; i < NV; i++) begin
      key_press_i  = VEC[i][7];
      load_state_i = VEC[i][6];
      irq_take_i   = VEC[i][5];
      ext_mask_i   = VEC[i][4];
      prog_reset_i = VEC[i][3];
      cyc();
      check($sformatf("vec%0d req R7", i), 32'(irq_req_o), 32'(VEC[i][2]));
      check($sformatf("vec%0d code R5", i), 32'(irq_code_o),
            32'((VEC[i][1] ? C_TMR : 16'h0) | (VEC[i][0] ? C_KEY : 16'h0)));
    end
    ext_mask_i = 1'b1;

    // R3 load then count down; R4 fire on crossing
    tmr_load_i = 1'b1; tmr_load_val_i = 32'd2; cyc();
    check("R3 load", tmr_val_o, 32'd2);
    tmr_tick_i = 1'b1; cyc();
    check("R3 tick", tmr_val_o, 32'd1);
    tmr_tick_i = 1'b1; cyc();
    check("R4 at zero no fire", 32'(irq_code_o), 32'd0);
    tmr_tick_i = 1'b1; cyc();
    check("R3 negative", tmr_val_o, 32'hffff_ffff);
    check("R4 fire code", 32'(irq_code_o), 32'(C_TMR));
    check("R4 fire req", 32'(irq_req_o), 32'd1);
    tmr_tick_i = 1'b1; cyc();
    check("R4 held", 32'(irq_code_o), 32'(C_TMR));

    // R5 merged code
    key_press_i = 1'b1; cyc();
    check("R5 merged", 32'(irq_code_o), 32'(C_TMR | C_KEY));

    // R6 key mask off hides key only
    cr0_wr_i = 1'b1; cr0_i = 32'h0100_0000; cyc();
    check("R6 key masked", 32'(irq_code_o), 32'(C_TMR));
    irq_take_i = 1'b1; cyc();
    check("R8 take reported", 32'(irq_code_o), 32'd0);
    check("R8 take req", 32'(irq_req_o), 32'd0);
    cr0_wr_i = 1'b1; cr0_i = 32'hffff_ffff; cyc();
    check("R8 masked key kept", 32'(irq_code_o), 32'(C_KEY));
    irq_take_i = 1'b1; cyc();
    check("R8 take key", 32'(irq_code_o), 32'd0);

    // R4 wrap from most negative
    tmr_load_i = 1'b1; tmr_load_val_i = 32'h8000_0000; cyc();
    tmr_tick_i = 1'b1; cyc();
    check("R4 wrap value", tmr_val_o, 32'h7fff_ffff);
    check("R4 wrap no fire", 32'(irq_code_o), 32'd0);

    // R3 load beats tick, R4 load to negative no fire
    tmr_load_i = 1'b1; tmr_load_val_i = 32'hffff_fff0; tmr_tick_i = 1'b1; cyc();
    check("R3 load wins", tmr_val_o, 32'hffff_fff0);
    check("R4 load no fire", 32'(irq_code_o), 32'd0);

    // R6 timer masked while firing, appears on unmask
    tmr_load_i = 1'b1; tmr_load_val_i = 32'd0; cyc();
    cr0_wr_i = 1'b1; cr0_i = 32'h0; cyc();
    tmr_tick_i = 1'b1; cyc();
    check("R6 tmr masked code", 32'(irq_code_o), 32'd0);
    check("R6 tmr masked req", 32'(irq_req_o), 32'd0);
    cr0_wr_i = 1'b1; cr0_i = 32'h0100_0000; cyc();
    check("R6 tmr unmasked", 32'(irq_code_o), 32'(C_TMR));

    // R9 program reset beats new event, timer kept
    prog_reset_i = 1'b1; key_press_i = 1'b1; cyc();
    cr0_wr_i = 1'b1; cr0_i = 32'hffff_ffff; cyc();
    check("R9 cleared", 32'(irq_code_o), 32'd0);
    check("R9 timer kept", tmr_val_o, 32'hffff_ffff);

    // R10 async reset
    key_press_i = 1'b1; cyc();
    cr0_wr_i = 1'b1; cr0_i = 32'h0; cyc();
    #1 rst_ni = 1'b0;
    #0.5;
    check("R10 async code", 32'(irq_code_o), 32'd0);
    check("R10 async timer", tmr_val_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    key_press_i = 1'b1; cyc();
    check("R10 mask reset one", 32'(irq_code_o), 32'(C_KEY));

    summary();
  end
endmodule